// File: doc/BRIEF.md
# Extension compare and arithmetic unit

This unit executes a small family of register-to-register extension instructions. All of them share the major opcode `6'b011100`. It takes a 32-bit instruction word and two 64-bit source operands, already read from the register file. It decodes the word and computes one of the following:

- a byte-truncated add;
- the low half of a 64x64 product;
- a population count over 32 or 64 bits;
- an equal or not-equal flag against a second register or against a signed 10-bit immediate.

The unit reports whether the word belonged to its family, which register to write, whether to write it, and the value.

The result is computed combinationally and captured in one output register stage. A word presented with `in_valid` high appears on the outputs one clock later, with `out_valid` high. The register file, the bitfield instructions and the branches sit outside this unit.

Top module: `xcmp_alu`

## Requirements
- R1: Byte add is selected by opcode `6'b011100`, function bits [5:0] = `6'b101000` and bits [10:6] = 0. The result is the low 8 bits of rs + rt, zero-extended. The destination is bits [15:11].
- R2: Multiply is selected by opcode `6'b011100`, function bits [5:0] = `6'b000011` and bits [10:6] = 0. The result is the low 64 bits of rs × rt. The destination is bits [15:11].
- R3: Population count is selected by opcode `6'b011100`, bits [5:1] = `5'b10110`, bits [20:16] = 0 and bits [10:6] = 0. With bit 0 = 1 it counts the set bits of all of rs. With bit 0 = 0 it counts only rs[31:0]. The count is zero-extended, and the destination is bits [15:11].
- R4: Register compare is selected by opcode `6'b011100`, bits [5:1] = `5'b10101` and bits [10:6] = 0. With bit 0 = 0 the result is 1 when rs equals rt. With bit 0 = 1 the result is 1 when they differ. Otherwise the result is 0. The destination is bits [15:11].
- R5: Immediate compare is selected by opcode `6'b011100` and bits [5:1] = `5'b10111`. Bits [15:6] form a signed 10-bit immediate, which is sign-extended to 64 bits and compared with rs. Bit 0 selects equal (0) or not-equal (1), and the 0/1 result goes to the register in bits [20:16].
- R6: A recognised instruction whose destination index is 0 raises `hit` but keeps `wr_en` low.
- R7: A word that matches none of R1 to R5 gives `hit` = 0, `wr_en` = 0, `dst_idx` = 0 and `result` = 0. This covers a wrong opcode, an unknown function code, and a nonzero must-be-zero field.
- R8: `out_valid` follows `in_valid` by exactly one clock. In a cycle after `in_valid` was low, `out_valid`, `hit` and `wr_en` are 0, and `dst_idx` and `result` keep their previous values.
- R9: While `rst_n` is low at a rising edge, all outputs are cleared to 0 on that edge (synchronous, active-low).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction word and operands are valid this cycle |
| instr | input | 32 | Instruction word |
| rs_val | input | DATA_W (64) | First source operand |
| rt_val | input | DATA_W (64) | Second source operand |
| out_valid | output | 1 | Registered outputs belong to an accepted word |
| hit | output | 1 | Word was one of this unit's instructions |
| dst_idx | output | 5 | Destination register index |
| wr_en | output | 1 | Write the result to `dst_idx` |
| result | output | DATA_W (64) | Computed value |

## Verification
There is only one register stage, so any wrong decode or arithmetic state appears at the ports on the very next clock. A misdecoded field shows up as a wrong `hit`, a wrong `dst_idx` or a spurious `wr_en`. A wrong datapath choice shows up as a wrong `result`. A register that updates while idle shows up the first cycle after `in_valid` drops: the held `result` and `dst_idx` change, or a stale `hit` remains. Sign extension and width selection are exposed by immediates at the extremes of the 10-bit range and by operands whose upper and lower halves differ.

// File: rtl/xcmp_pkg.sv
// Shared constants and types for the extension compare/arithmetic unit.
// Assumes the fixed 32-bit instruction layout; only data width is tunable.
package xcmp_pkg;

    localparam int INSTR_W   = 32;
    localparam int REG_IDX_W = 5;
    localparam int IMM_W     = 10;
    localparam int BYTE_W    = 8;

    localparam logic [5:0] OPC_MAJOR = 6'b011100;
    localparam logic [5:0] FN_BADD   = 6'b101000;
    localparam logic [5:0] FN_DMUL   = 6'b000011;
    localparam logic [4:0] SUB_POP   = 5'b10110;
    localparam logic [4:0] SUB_CMPR  = 5'b10101;
    localparam logic [4:0] SUB_CMPI  = 5'b10111;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_BADD,
        OP_MUL,
        OP_POP,
        OP_CMPR,
        OP_CMPI
    } op_e;

    typedef struct packed {
        op_e                  op;
        logic                 wide;   // popcount over full width
        logic                 neg;    // compare: not-equal sense
        logic [REG_IDX_W-1:0] dst;
        logic [IMM_W-1:0]     imm;
    } dec_t;

endpackage

// File: rtl/xcmp_decode.sv
// Instruction decoder: maps one 32-bit word to an operation, destination
// register and immediate. Words outside the family decode to OP_NONE with
// destination 0. Assumes the rs field is consumed by the register file.
module xcmp_decode
    import xcmp_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output dec_t               dec
);

    logic [5:0]           opc;
    logic [REG_IDX_W-1:0] rt_f;
    logic [REG_IDX_W-1:0] rd_f;
    logic [4:0]           sa_f;
    logic [5:0]           fn_f;
    logic                 unused_rs_field;

    assign opc  = instr[31:26];
    assign rt_f = instr[20:16];
    assign rd_f = instr[15:11];
    assign sa_f = instr[10:6];
    assign fn_f = instr[5:0];
    assign unused_rs_field = ^instr[25:21];

    // Select the operation by function code and check must-be-zero fields.
    always_comb begin
        dec = '{op: OP_NONE, default: '0};
        if (opc == OPC_MAJOR) begin
            if (fn_f == FN_BADD && sa_f == '0) begin
                dec.op  = OP_BADD;
                dec.dst = rd_f;
            end else if (fn_f == FN_DMUL && sa_f == '0) begin
                dec.op  = OP_MUL;
                dec.dst = rd_f;
            end else if (fn_f[5:1] == SUB_POP && sa_f == '0 && rt_f == '0) begin
                dec.op   = OP_POP;
                dec.wide = fn_f[0];
                dec.dst  = rd_f;
            end else if (fn_f[5:1] == SUB_CMPR && sa_f == '0) begin
                dec.op  = OP_CMPR;
                dec.neg = fn_f[0];
                dec.dst = rd_f;
            end else if (fn_f[5:1] == SUB_CMPI) begin
                dec.op  = OP_CMPI;
                dec.neg = fn_f[0];
                dec.dst = rt_f;
                dec.imm = instr[15:6];
            end
        end
    end

endmodule

// File: rtl/xcmp_popcnt.sv
// Population counter: number of set bits in a WIDTH-bit value.
// Assumes the caller masks any bits that must not be counted.
module xcmp_popcnt #(
    parameter int WIDTH = 64,
    localparam int CNT_W = $clog2(WIDTH + 1)
) (
    input  logic [WIDTH-1:0] val,
    output logic [CNT_W-1:0] cnt
);

    // Accumulate one bit at a time; synthesis builds an adder tree.
    always_comb begin
        cnt = '0;
        for (int i = 0; i < WIDTH; i++) begin
            cnt = cnt + CNT_W'(val[i]);
        end
    end

endmodule

// File: rtl/xcmp_execute.sv
// Datapath: computes the result for a decoded operation from rs and rt.
// OP_NONE yields zero. Assumes DATA_W is even and at least 16.
module xcmp_execute
    import xcmp_pkg::*;
#(
    parameter int DATA_W = 64,
    localparam int HALF_W = DATA_W / 2,
    localparam int CNT_W  = $clog2(DATA_W + 1)
) (
    input  dec_t              dec,
    input  logic [DATA_W-1:0] rs_val,
    input  logic [DATA_W-1:0] rt_val,
    output logic [DATA_W-1:0] result
);

    logic [DATA_W-1:0] pop_src;
    logic [CNT_W-1:0]  pop_cnt;
    logic [BYTE_W-1:0] byte_sum;
    logic [DATA_W-1:0] product;
    logic [DATA_W-1:0] imm_ext;
    logic              eq_reg;
    logic              eq_imm;

    // Narrow popcount sees only the low half of rs.
    assign pop_src = dec.wide ? rs_val : {{HALF_W{1'b0}}, rs_val[HALF_W-1:0]};

    xcmp_popcnt #(.WIDTH(DATA_W)) u_popcnt (
        .val (pop_src),
        .cnt (pop_cnt)
    );

    assign byte_sum = rs_val[BYTE_W-1:0] + rt_val[BYTE_W-1:0];
    assign product  = rs_val * rt_val;
    assign imm_ext  = {{(DATA_W-IMM_W){dec.imm[IMM_W-1]}}, dec.imm};
    assign eq_reg   = (rs_val == rt_val);
    assign eq_imm   = (rs_val == imm_ext);

    // Pick the operation result; flags are zero-extended single bits.
    always_comb begin
        result = '0;
        case (dec.op)
            OP_BADD: result = {{(DATA_W-BYTE_W){1'b0}}, byte_sum};
            OP_MUL:  result = product;
            OP_POP:  result = {{(DATA_W-CNT_W){1'b0}}, pop_cnt};
            OP_CMPR: result = {{(DATA_W-1){1'b0}}, eq_reg ^ dec.neg};
            OP_CMPI: result = {{(DATA_W-1){1'b0}}, eq_imm ^ dec.neg};
            default: result = '0;
        endcase
    end

endmodule

// File: rtl/xcmp_alu.sv
// Top of the extension compare/arithmetic unit: decode, execute and one
// output register stage with a valid strobe. Assumes operands are already
// read from the register file in the same cycle as the instruction word.
module xcmp_alu
    import xcmp_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [INSTR_W-1:0]   instr,
    input  logic [DATA_W-1:0]    rs_val,
    input  logic [DATA_W-1:0]    rt_val,
    output logic                 out_valid,
    output logic                 hit,
    output logic [REG_IDX_W-1:0] dst_idx,
    output logic                 wr_en,
    output logic [DATA_W-1:0]    result
);

    dec_t              dec;
    logic [DATA_W-1:0] exec_res;
    logic              hit_c;

    xcmp_decode u_decode (
        .instr (instr),
        .dec   (dec)
    );

    xcmp_execute #(.DATA_W(DATA_W)) u_execute (
        .dec    (dec),
        .rs_val (rs_val),
        .rt_val (rt_val),
        .result (exec_res)
    );

    assign hit_c = (dec.op != OP_NONE);

    // Output stage: strobes track in_valid, data loads only on a valid word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            hit       <= 1'b0;
            wr_en     <= 1'b0;
            dst_idx   <= '0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            hit       <= in_valid && hit_c;
            wr_en     <= in_valid && hit_c && (dec.dst != '0);
            if (in_valid) begin
                dst_idx <= dec.dst;
                result  <= exec_res;
            end
        end
    end

endmodule

// File: rtl/xcmp_alu_chk.sv
// Assertion checker for xcmp_alu, attached by bind. Observes ports only.
module xcmp_alu_chk #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [31:0]       instr,
    input logic              out_valid,
    input logic              hit,
    input logic [4:0]        dst_idx,
    input logic              wr_en,
    input logic [DATA_W-1:0] result
);

    logic in_family;
    logic is_badd;
    logic is_pop;
    logic is_cmpr;
    logic unused_instr_bits;

    assign in_family = in_valid && (instr[31:26] == 6'b011100);
    assign is_badd   = in_family && instr[5:0] == 6'b101000 && instr[10:6] == 5'd0;
    assign is_pop    = in_family && instr[5:1] == 5'b10110 && instr[10:6] == 5'd0
                       && instr[20:16] == 5'd0;
    assign is_cmpr   = in_family && instr[5:1] == 5'b10101 && instr[10:6] == 5'd0;
    assign unused_instr_bits = ^instr[25:11];

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !hit && !wr_en)); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(dst_idx))); // R8
    AST_WRITE_NEEDS_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (hit && dst_idx != 5'd0)); // R6
    AST_FOREIGN_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[31:26] != 6'b011100) |=> (!hit && !wr_en)); // R7
    AST_BYTE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        is_badd |=> (result[DATA_W-1:8] == '0)); // R1
    AST_POP_WIDE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (is_pop && instr[0]) |=> (result <= DATA_W'(DATA_W))); // R3
    AST_POP_NARROW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (is_pop && !instr[0]) |=> (result <= DATA_W'(DATA_W / 2))); // R3
    AST_FLAG_BINARY: assert property (@(posedge clk) disable iff (!rst_n)
        is_cmpr |=> (hit && result[DATA_W-1:1] == '0)); // R4
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !hit && !wr_en && result == '0)); // R9

endmodule

bind xcmp_alu xcmp_alu_chk #(.DATA_W(DATA_W)) u_xcmp_alu_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .instr     (instr),
    .out_valid (out_valid),
    .hit       (hit),
    .dst_idx   (dst_idx),
    .wr_en     (wr_en),
    .result    (result)
);

// File: tb/test_xcmp_alu.sv
`timescale 1ns/1ps
module test_xcmp_alu;

    localparam int DW = 64;
    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

    typedef struct packed {
        logic [31:0] instr;
        logic [63:0] rs;
        logic [63:0] rt;
        logic        hit;
        logic        wr;
        logic [4:0]  dst;
        logic [63:0] res;
        logic [3:0]  req;
    } vec_t;

    // Register-form word: opcode, rs, rt, rd, shift field, function.
    function automatic logic [31:0] mk_r(input logic [4:0] a, input logic [4:0] b,
                                         input logic [4:0] d, input logic [4:0] s,
                                         input logic [5:0] f);
        return {6'b011100, a, b, d, s, f};
    endfunction

    // Immediate-form word: opcode, rs, destination, 10-bit immediate, function.
    function automatic logic [31:0] mk_i(input logic [4:0] a, input logic [4:0] d,
                                         input logic [9:0] imm, input logic [5:0] f);
        return {6'b011100, a, d, imm, f};
    endfunction

    localparam int NV = 25;
    localparam vec_t VECS [NV] = '{
        '{mk_r(1,2,3,0,6'b101000), 64'hFF, 64'h02, 1'b1, 1'b1, 5'd3, 64'h01, 4'd1},           // R1 carry dropped
        '{mk_r(1,2,3,0,6'b101000), 64'h1234_0000_0000_00F0, 64'h20, 1'b1, 1'b1, 5'd3, 64'h10, 4'd1}, // R1
        '{mk_r(1,2,4,0,6'b000011), ONES, 64'd3, 1'b1, 1'b1, 5'd4, 64'hFFFF_FFFF_FFFF_FFFD, 4'd2}, // R2
        '{mk_r(1,2,4,0,6'b000011), 64'h1_0000_0001, 64'h1_0000_0001, 1'b1, 1'b1, 5'd4,
          64'h0000_0002_0000_0001, 4'd2},                                                        // R2 overflow
        '{mk_r(1,0,5,0,6'b101101), ONES, 64'd0, 1'b1, 1'b1, 5'd5, 64'd64, 4'd3},               // R3 wide
        '{mk_r(1,0,5,0,6'b101100), ONES, 64'd0, 1'b1, 1'b1, 5'd5, 64'd32, 4'd3},               // R3 narrow
        '{mk_r(1,0,5,0,6'b101100), 64'hFFFF_FFFF_0000_000F, 64'd0, 1'b1, 1'b1, 5'd5, 64'd4, 4'd3}, // R3
        '{mk_r(1,0,5,0,6'b101101), 64'h8000_0000_0000_0001, 64'd0, 1'b1, 1'b1, 5'd5, 64'd2, 4'd3}, // R3
        '{mk_r(1,2,6,0,6'b101010), 64'd5, 64'd5, 1'b1, 1'b1, 5'd6, 64'd1, 4'd4},               // R4 eq true
        '{mk_r(1,2,6,0,6'b101010), 64'd5, 64'd6, 1'b1, 1'b1, 5'd6, 64'd0, 4'd4},               // R4 eq false
        '{mk_r(1,2,6,0,6'b101011), 64'd5, 64'd6, 1'b1, 1'b1, 5'd6, 64'd1, 4'd4},               // R4 ne true
        '{mk_r(1,2,6,0,6'b101011), 64'hDEAD_BEEF_0000_0001, 64'hDEAD_BEEF_0000_0001,
          1'b1, 1'b1, 5'd6, 64'd0, 4'd4},                                                        // R4 ne false
        '{mk_i(1,7,10'h3FF,6'b101110), ONES, 64'd0, 1'b1, 1'b1, 5'd7, 64'd1, 4'd5},            // R5 -1
        '{mk_i(1,7,10'h3FF,6'b101110), 64'h3FF, 64'd0, 1'b1, 1'b1, 5'd7, 64'd0, 4'd5},         // R5 sign ext
        '{mk_i(1,7,10'h1FF,6'b101111), 64'h1FF, 64'd0, 1'b1, 1'b1, 5'd7, 64'd0, 4'd5},         // R5 max pos
        '{mk_i(1,8,10'h200,6'b101110), 64'hFFFF_FFFF_FFFF_FE00, 64'd0, 1'b1, 1'b1, 5'd8, 64'd1, 4'd5}, // R5 min
        '{mk_i(1,8,10'h200,6'b101111), 64'h200, 64'd0, 1'b1, 1'b1, 5'd8, 64'd1, 4'd5},         // R5 ne
        '{mk_r(1,2,0,0,6'b101000), 64'd1, 64'd2, 1'b1, 1'b0, 5'd0, 64'd3, 4'd6},               // R6 rd zero
        '{mk_i(1,0,10'h005,6'b101110), 64'd5, 64'd0, 1'b1, 1'b0, 5'd0, 64'd1, 4'd6},           // R6 rt zero
        '{{6'b000000,5'd1,5'd2,5'd3,5'd0,6'b101000}, 64'd1, 64'd2, 1'b0, 1'b0, 5'd0, 64'd0, 4'd7}, // R7 opcode
        '{mk_r(1,2,3,1,6'b101000), 64'd1, 64'd2, 1'b0, 1'b0, 5'd0, 64'd0, 4'd7},               // R7 shift field
        '{mk_r(1,2,5,0,6'b101101), ONES, 64'd0, 1'b0, 1'b0, 5'd0, 64'd0, 4'd7},                // R7 pop rt!=0
        '{mk_r(1,2,3,0,6'b111111), 64'd1, 64'd2, 1'b0, 1'b0, 5'd0, 64'd0, 4'd7},               // R7 funct
        '{mk_r(1,2,6,4,6'b101010), 64'd5, 64'd5, 1'b0, 1'b0, 5'd0, 64'd0, 4'd7},               // R7 cmp sa
        '{mk_r(1,2,4,0,6'b000011), 64'd7, 64'd6, 1'b1, 1'b1, 5'd4, 64'd42, 4'd2}               // R2
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [31:0]   instr = '0;
    logic [DW-1:0] rs_val = '0;
    logic [DW-1:0] rt_val = '0;
    logic          out_valid;
    logic          hit;
    logic [4:0]    dst_idx;
    logic          wr_en;
    logic [DW-1:0] result;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    xcmp_alu #(.DATA_W(DW)) i_xcmp_alu (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .instr     (instr),
        .rs_val    (rs_val),
        .rt_val    (rt_val),
        .out_valid (out_valid),
        .hit       (hit),
        .dst_idx   (dst_idx),
        .wr_en     (wr_en),
        .result    (result)
    );

    task automatic check(input string what, input logic [71:0] act, input logic [71:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // Outputs packed as {out_valid, hit, wr_en, dst_idx, result}.
    function automatic logic [71:0] pack_out();
        return {out_valid, hit, wr_en, dst_idx, result};
    endfunction

    task automatic apply_vec(input vec_t v, input int idx);
        in_valid = 1'b1;
        instr    = v.instr;
        rs_val   = v.rs;
        rt_val   = v.rt;
        @(negedge clk);
        check($sformatf("R%0d vector %0d", v.req, idx), pack_out(),
              {1'b1, v.hit, v.wr, v.dst, v.res});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 reset state", pack_out(), 72'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply_vec(VECS[i], i);
        end

        // R8: idle cycle holds data and drops strobes
        apply_vec('{mk_r(1,2,9,0,6'b101000), 64'h10, 64'h20, 1'b1, 1'b1, 5'd9, 64'h30, 4'd8}, 100);
        in_valid = 1'b0;
        instr    = mk_r(1,2,11,0,6'b000011);
        rs_val   = 64'd9;
        rt_val   = 64'd9;
        @(negedge clk);
        check("R8 idle holds", pack_out(), {1'b0, 1'b0, 1'b0, 5'd9, 64'h30});
        @(negedge clk);
        check("R8 idle second cycle", pack_out(), {1'b0, 1'b0, 1'b0, 5'd9, 64'h30});

        // R8: valid right after idle
        apply_vec('{mk_r(1,2,11,0,6'b000011), 64'd9, 64'd9, 1'b1, 1'b1, 5'd11, 64'd81, 4'd8}, 101);

        // R9: reset mid-run overrides a valid hit word
        rst_n    = 1'b0;
        in_valid = 1'b1;
        instr    = mk_r(1,2,3,0,6'b101000);
        rs_val   = 64'd1;
        rt_val   = 64'd1;
        @(negedge clk);
        check("R9 reset mid-run", pack_out(), 72'd0);
        rst_n    = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);
        check("R9 after reset idle", pack_out(), 72'd0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule